// File: doc/BRIEF.md
# Serial Receiver Standby and Interrupt Gate

This block sits next to an asynchronous serial transmitter/receiver pair. It holds the six control bits that govern interrupt enables, receiver enable, receiver standby and the standby exit method. It merges the transmit-complete, receive-full, overrun and line-idle status flags into one level interrupt request. It also manages a receiver standby state that the hardware leaves by itself when the selected wakeup event arrives.

The data path keeps ownership of its status flags and only reads this block's outputs. It may set its receive-side flags only while `rx_active` is high, so a receiver in standby produces no new flags and no receiver interrupts. Turning the receiver off removes the receive-side sources from the request and leaves the flags untouched, so turning it back on brings back any request that is still pending.

Top module: `sci_wake_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every control bit. After reset `irq`, `rx_active` and `standby_q` are 0 even with all four flags at 1.
- R2: With control bit 0 (transmit-complete enable) at 1, a high `txdone_flag` drives `irq` high in the same cycle. With bit 0 at 0 it does not.
- R3: With control bit 1 (receive enable for interrupts) at 1 and the receiver enabled, a high `rxfull_flag` or a high `overrun_flag` drives `irq` high.
- R4: With control bit 2 (idle interrupt enable) at 1 and the receiver enabled, a high `idle_flag` drives `irq` high.
- R5: With control bit 3 (receiver enable) at 0, the three receive-side flags have no effect on `irq`, while the transmit-complete source still works. Setting bit 3 again with a flag still high raises `irq` again at once.
- R6: `irq` is the combinational OR of all enabled sources. It stays high for as long as any enabled flag stays high.
- R7: A cycle with `ctrl_wr` high loads `ctrl_wdata` into all six control bits at the next clock edge. The fields are bit 0 transmit-complete enable, bit 1 receive/overrun enable, bit 2 idle enable, bit 3 receiver enable, bit 4 standby, bit 5 wake select.
- R8: `rx_active` is 1 exactly when the receiver is enabled and not in standby. `standby_q` shows the live standby bit.
- R9: With wake select (bit 5) at 0, a `line_idle_evt` in standby clears standby at the next edge. A frame with its address bit set does not.
- R10: With wake select at 1, a `frame_evt` with `frame_addr_bit` high in standby clears standby at the next edge. An idle event, or a frame with the address bit low, does not.
- R11: When a write that sets the standby bit lands in the same cycle as a wakeup, the hardware clear wins and standby reads 0 afterwards.
- R12: A wakeup event has no effect while the receiver is disabled or not in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write value (fields in R7) |
| txdone_flag | input | 1 | Transmit-complete status flag |
| rxfull_flag | input | 1 | Receive-data-full status flag |
| overrun_flag | input | 1 | Overrun status flag |
| idle_flag | input | 1 | Idle-line status flag |
| line_idle_evt | input | 1 | One-cycle pulse: idle line seen by receiver |
| frame_evt | input | 1 | One-cycle pulse: a frame was received |
| frame_addr_bit | input | 1 | Address mark of the frame flagged by frame_evt |
| irq | output | 1 | Level interrupt request |
| rx_active | output | 1 | Receiver may set its flags this cycle |
| standby_q | output | 1 | Current standby bit |

## Verification
The assertions assume the control inputs are driven to known values from reset onward. They also assume `frame_addr_bit` matters only in a cycle where `frame_evt` is high, and that the flag inputs are plain levels with no ordering tied to the events. The stimulus keeps to these assumptions: it drives every input one cycle at a time from a fixed-seed `$urandom` stream and from directed steps. It writes the control register only now and then, so standby periods last long enough for matching and non-matching wakeup events to arrive. The event inputs are drawn independently, so an idle event and an addressed frame sometimes land together, and some events come while the receiver is disabled.

// File: rtl/sci_wk_pkg.sv
package sci_wk_pkg;

    typedef struct packed {
        logic wake_addr;   // bit 5: 1 = address mark wakes, 0 = idle line wakes
        logic standby;     // bit 4
        logic rx_en;       // bit 3
        logic idle_ie;     // bit 2
        logic rx_ie;       // bit 1: receive-full and overrun
        logic txdone_ie;   // bit 0
    } wk_ctrl_t;

    localparam int CTRL_W  = $bits(wk_ctrl_t);
    localparam int NUM_SRC = 4;

    localparam int SRC_TXDONE  = 0;
    localparam int SRC_RXFULL  = 1;
    localparam int SRC_OVERRUN = 2;
    localparam int SRC_IDLE    = 3;

    // sources that belong to the receiver and are masked by rx_en
    localparam logic [NUM_SRC-1:0] RX_SRC_MASK = 4'b1110;

    function automatic logic [NUM_SRC-1:0] src_enables(input wk_ctrl_t c);
        logic [NUM_SRC-1:0] e;
        e              = '0;
        e[SRC_TXDONE]  = c.txdone_ie;
        e[SRC_RXFULL]  = c.rx_ie;
        e[SRC_OVERRUN] = c.rx_ie;
        e[SRC_IDLE]    = c.idle_ie;
        return e;
    endfunction

endpackage

// File: rtl/sci_wk_wake_detect.sv
module sci_wk_wake_detect
    import sci_wk_pkg::*;
(
    input  wk_ctrl_t ctrl,
    input  logic     line_idle_evt,
    input  logic     frame_evt,
    input  logic     frame_addr_bit,
    output logic     wake_hit,
    output logic     rx_active
);
    logic addr_mark;
    logic sel_event;

    always_comb begin
        addr_mark = frame_evt & frame_addr_bit;
        sel_event = ctrl.wake_addr ? addr_mark : line_idle_evt;
        wake_hit  = ctrl.rx_en & ctrl.standby & sel_event;
        rx_active = ctrl.rx_en & ~ctrl.standby;
    end
endmodule

// File: rtl/sci_wk_ctrl_regs.sv
module sci_wk_ctrl_regs
    import sci_wk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  wk_ctrl_t wdata,
    input  logic     wake_hit,
    output wk_ctrl_t ctrl_q
);
    wk_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = wdata;
        end
        // hardware wakeup clear overrides any software value this cycle
        if (wake_hit) begin
            ctrl_d.standby = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0));

    a_r9_wake_clears_standby: assert property (@(posedge clk) disable iff (rst)
        wake_hit |=> !ctrl_q.standby);

    a_r11_hw_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata.standby && wake_hit) |=> !ctrl_q.standby);

    a_r7_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr && !wake_hit) |=> (ctrl_q == $past(wdata)));

    a_r12_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (!wr && !wake_hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/sci_wk_irq_merge.sv
module sci_wk_irq_merge #(
    parameter int                 NSRC    = 4,
    parameter logic [NSRC-1:0]    RX_MASK = '0
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    input  logic            rx_en,
    output logic            irq
);
    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (RX_MASK[i]) begin : g_rx
            assign gated[i] = flags[i] & enables[i] & rx_en;
        end else begin : g_plain
            assign gated[i] = flags[i] & enables[i];
        end
    end

    assign irq = |gated;
endmodule

// File: rtl/sci_wake_irq_ctrl.sv
module sci_wake_irq_ctrl
    import sci_wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              txdone_flag,
    input  logic              rxfull_flag,
    input  logic              overrun_flag,
    input  logic              idle_flag,
    input  logic              line_idle_evt,
    input  logic              frame_evt,
    input  logic              frame_addr_bit,
    output logic              irq,
    output logic              rx_active,
    output logic              standby_q
);
    wk_ctrl_t           ctrl;
    wk_ctrl_t           wdata;
    logic               wake_hit;
    logic [NUM_SRC-1:0] flags;

    assign wdata = wk_ctrl_t'(ctrl_wdata);

    always_comb begin
        flags              = '0;
        flags[SRC_TXDONE]  = txdone_flag;
        flags[SRC_RXFULL]  = rxfull_flag;
        flags[SRC_OVERRUN] = overrun_flag;
        flags[SRC_IDLE]    = idle_flag;
    end

    sci_wk_wake_detect u_wake (
        .ctrl           (ctrl),
        .line_idle_evt  (line_idle_evt),
        .frame_evt      (frame_evt),
        .frame_addr_bit (frame_addr_bit),
        .wake_hit       (wake_hit),
        .rx_active      (rx_active)
    );

    sci_wk_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctrl_wr),
        .wdata    (wdata),
        .wake_hit (wake_hit),
        .ctrl_q   (ctrl)
    );

    sci_wk_irq_merge #(
        .NSRC    (NUM_SRC),
        .RX_MASK (RX_SRC_MASK)
    ) u_irq (
        .flags   (flags),
        .enables (src_enables(ctrl)),
        .rx_en   (ctrl.rx_en),
        .irq     (irq)
    );

    assign standby_q = ctrl.standby;

    a_r5_rx_sources_masked: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rx_en |-> (irq == (txdone_flag && ctrl.txdone_ie)));

    a_r6_level_holds: assert property (@(posedge clk) disable iff (rst)
        (txdone_flag && ctrl.txdone_ie) |-> irq);

    a_r8_active_not_standby: assert property (@(posedge clk) disable iff (rst)
        rx_active |-> (!standby_q && ctrl.rx_en));

    a_r4_idle_source: assert property (@(posedge clk) disable iff (rst)
        (idle_flag && ctrl.idle_ie && ctrl.rx_en) |-> irq);
endmodule

// File: tb/tb_sci_wake_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sci_wake_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic       txdone_flag = 1'b0, rxfull_flag = 1'b0, overrun_flag = 1'b0, idle_flag = 1'b0;
    logic       line_idle_evt = 1'b0, frame_evt = 1'b0, frame_addr_bit = 1'b0;
    logic       irq, rx_active, standby_q;

    int checks = 0;
    int errors = 0;

    // bench model of the six control bits
    logic [5:0] m = '0;

    always #2.5 clk = ~clk;

    sci_wake_irq_ctrl dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .txdone_flag(txdone_flag), .rxfull_flag(rxfull_flag),
        .overrun_flag(overrun_flag), .idle_flag(idle_flag),
        .line_idle_evt(line_idle_evt), .frame_evt(frame_evt),
        .frame_addr_bit(frame_addr_bit),
        .irq(irq), .rx_active(rx_active), .standby_q(standby_q)
    );

    function automatic logic exp_irq(input logic [5:0] c, input logic [3:0] f);
        // f: {idle, overrun, rxfull, txdone}
        return (f[0] & c[0]) | (c[3] & ((c[1] & (f[1] | f[2])) | (c[2] & f[3])));
    endfunction

    function automatic logic exp_hit(input logic [5:0] c, input logic ie, input logic fe,
                                     input logic ab);
        return c[3] & c[4] & (c[5] ? (fe & ab) : ie);
    endfunction

    function automatic logic [5:0] next_ctrl(input logic [5:0] c, input logic wr,
                                             input logic [5:0] wd, input logic hit);
        logic [5:0] n;
        n = wr ? wd : c;
        if (hit) n[4] = 1'b0;
        return n;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [5:0] wd, input logic [3:0] f,
                        input logic ie, input logic fe, input logic ab, input string tag);
        @(negedge clk);
        ctrl_wr = wr; ctrl_wdata = wd;
        txdone_flag = f[0]; rxfull_flag = f[1]; overrun_flag = f[2]; idle_flag = f[3];
        line_idle_evt = ie; frame_evt = fe; frame_addr_bit = ab;
        #1;
        chk(tag, "irq", irq, exp_irq(m, f));
        chk(tag, "rx_active", rx_active, m[3] & ~m[4]);
        chk(tag, "standby_q", standby_q, m[4]);
        @(posedge clk);
        m = next_ctrl(m, wr, wd, exp_hit(m, ie, fe, ab));
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5C1A_77E1;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m = '0;

        // R1: reset values with every flag high
        step(0, 6'h00, 4'hF, 0, 0, 0, "R1");
        // R7: write transmit enable and receiver enable
        step(1, 6'b001001, 4'h0, 0, 0, 0, "R7");
        step(0, 6'h00, 4'b0001, 0, 0, 0, "R2");
        step(0, 6'h00, 4'b1110, 0, 0, 0, "R3");
        step(1, 6'b001110, 4'b0001, 0, 0, 0, "R2");
        step(1, 6'b001111, 4'h0, 0, 0, 0, "R7");
        step(0, 6'h00, 4'b0010, 0, 0, 0, "R3");
        step(0, 6'h00, 4'b0100, 0, 0, 0, "R3");
        step(0, 6'h00, 4'b1000, 0, 0, 0, "R4");
        // R6: level held over several cycles
        repeat (4) step(0, 6'h00, 4'b1000, 0, 0, 0, "R6");
        step(0, 6'h00, 4'b0000, 0, 0, 0, "R6");
        // R5: receiver disabled masks receive sources only
        step(1, 6'b000111, 4'b1110, 0, 0, 0, "R5");
        step(0, 6'h00, 4'b1110, 0, 0, 0, "R5");
        step(0, 6'h00, 4'b1111, 0, 0, 0, "R5");
        step(1, 6'b001111, 4'b0010, 0, 0, 0, "R5");
        step(0, 6'h00, 4'b0010, 0, 0, 0, "R5");
        // R8 and R9: standby, idle-line wake
        step(1, 6'b011111, 4'h0, 0, 0, 0, "R8");
        step(0, 6'h00, 4'h0, 0, 1, 1, "R9");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R9");
        step(0, 6'h00, 4'h0, 1, 0, 0, "R9");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R8");
        // R10: address-mark wake
        step(1, 6'b111111, 4'h0, 0, 0, 0, "R10");
        step(0, 6'h00, 4'h0, 1, 0, 0, "R10");
        step(0, 6'h00, 4'h0, 0, 1, 0, "R10");
        step(0, 6'h00, 4'h0, 0, 0, 1, "R10");
        step(0, 6'h00, 4'h0, 0, 1, 1, "R10");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R10");
        // R11: write setting standby collides with a wakeup
        step(1, 6'b111111, 4'h0, 0, 0, 0, "R11");
        step(1, 6'b111111, 4'h0, 0, 1, 1, "R11");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R11");
        // R12: wake events with receiver off, then outside standby
        step(1, 6'b110111, 4'h0, 0, 0, 0, "R12");
        step(0, 6'h00, 4'h0, 1, 1, 1, "R12");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R12");
        step(1, 6'b101111, 4'h0, 0, 0, 0, "R12");
        step(0, 6'h00, 4'h0, 1, 1, 1, "R12");
        step(0, 6'h00, 4'h0, 0, 0, 0, "R12");

        // random mix: checks cover R2 R3 R4 R5 R6 R8 R9 R10 R11
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [5:0] d;
            w = ($urandom % 8) == 0;
            d = 6'($urandom);
            step(w, d, 4'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 3 == 0),
                 1'($urandom), "R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule